// File: doc/BRIEF.md
# Level-Encoded Dual-Rail Link Endpoints

This block holds both ends of a two-wire-per-bit link. The transmit side takes a word on a valid/ready strobe and moves a pair of wires for every bit. One wire always shows the bit's logic value. The other wire, the phase wire, is toggled only when the bit keeps its old value. Each transfer therefore flips exactly one wire of each pair and never returns to zero. After each accepted word the transmit side holds ready low for one cycle.

The receive side watches the wire pairs. It forms each bit's parity, the XOR of the value wire and the phase wire, and compares it with a single expected-parity bit. When every bit shows the flipped parity, a new token has arrived. The decoder then presents the value wires as a word with a one-cycle valid pulse and inverts its expected parity. If some bits have flipped and others have not for more than a set number of consecutive cycles, a sticky skew error is raised.

The transmit wires and the receive wires are separate ports. The integrator connects them through whatever channel lies between the two ends. After reset every wire is low and the expected parity is 0.

Top module: `ledr_link`

## Requirements
- R1: While reset is high and on the cycle after it falls, every transmit wire is 0, tx_ready is 1, rx_valid is 0 and rx_skew_err is 0.
- R2: On the cycle after a word is accepted (tx_valid and tx_ready both high at a clock edge), tx_val_w equals that word.
- R3: For an accepted word, each bit toggles exactly one of its two wires. The value wire toggles when the new bit differs from the previous one; otherwise the phase wire toggles.
- R4: tx_ready is 0 for exactly the one cycle that follows an accepted word and is 1 again on the cycle after that.
- R5: If tx_valid is high while tx_ready is 0, nothing is accepted and both transmit wire buses keep their values.
- R6: After a clock edge at which every bit's parity (rx_val_w[i] XOR rx_phs_w[i]) differs from the expected parity, rx_valid is 1 for exactly one cycle with rx_word equal to the rx_val_w sampled at that edge. The expected parity starts at 0 and inverts with each token.
- R7: While only some bits show the flipped parity, rx_valid stays 0.
- R8: A split parity sampled at no more than SKEW_LIMIT consecutive clock edges leaves rx_skew_err at 0.
- R9: A split parity sampled at SKEW_LIMIT+1 consecutive edges sets rx_skew_err, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | A word is offered to the encoder |
| tx_word | input | WIDTH | Word to send |
| tx_ready | output | 1 | Encoder can accept a word |
| tx_val_w | output | WIDTH | Transmit value wires |
| tx_phs_w | output | WIDTH | Transmit phase wires |
| rx_val_w | input | WIDTH | Receive value wires |
| rx_phs_w | input | WIDTH | Receive phase wires |
| rx_valid | output | 1 | One-cycle pulse marking a decoded word |
| rx_word | output | WIDTH | Decoded word |
| rx_skew_err | output | 1 | Sticky flag for parity disagreement held too long |

## Verification
The bench builds the block with WIDTH of 8 and SKEW_LIMIT of 3. An 8-bit word lets the random stream hit all-value-toggle, all-phase-toggle and mixed transfers many times each. A limit of 3 puts both sides of the skew boundary, three split edges and then four, only a few cycles apart. Random words pass through an ideal loopback. Forced wire patterns then create skew that the loopback cannot produce.

// File: rtl/ledr_pkg.sv
package ledr_pkg;

    typedef enum logic [1:0] {
        PAR_HOLD  = 2'd0,
        PAR_TOKEN = 2'd1,
        PAR_SPLIT = 2'd2
    } par_class_t;

    function automatic logic phase_next(input logic cur_val, input logic cur_phs,
                                        input logic new_bit);
        return (new_bit == cur_val) ? ~cur_phs : cur_phs;
    endfunction

    function automatic par_class_t classify(input logic all_flipped, input logic all_same);
        if (all_flipped)
            return PAR_TOKEN;
        else if (all_same)
            return PAR_HOLD;
        else
            return PAR_SPLIT;
    endfunction

endpackage

// File: rtl/ledr_enc.sv
module ledr_enc #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_word,
    output logic             in_ready,
    output logic [WIDTH-1:0] val_w,
    output logic [WIDTH-1:0] phs_w
);
    logic             busy_q;
    logic             take;
    logic [WIDTH-1:0] val_q;
    logic [WIDTH-1:0] phs_q;
    logic [WIDTH-1:0] phs_nxt;

    assign take     = in_valid && !busy_q;
    assign in_ready = !busy_q;
    assign val_w    = val_q;
    assign phs_w    = phs_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign phs_nxt[i] = ledr_pkg::phase_next(val_q[i], phs_q[i], in_word[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            val_q  <= '0;
            phs_q  <= '0;
        end else begin
            busy_q <= take;
            if (take) begin
                val_q <= in_word;
                phs_q <= phs_nxt;
            end
        end
    end

    assert_value_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (val_w == $past(in_word)));

    assert_one_wire_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=>
            (((val_w ^ $past(val_w)) ^ (phs_w ^ $past(phs_w))) == {WIDTH{1'b1}}));

    assert_ready_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_hold_wires_R5: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ($stable(val_w) && $stable(phs_w)));

endmodule

// File: rtl/ledr_skew_mon.sv
module ledr_skew_mon #(
    parameter int SKEW_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic split,
    output logic err
);
    localparam int CW = $clog2(SKEW_LIMIT + 1) + 1;

    logic [CW-1:0] run_q;
    logic          err_q;

    assign err = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            err_q <= 1'b0;
        end else if (!split) begin
            run_q <= '0;
        end else if (run_q == CW'(SKEW_LIMIT)) begin
            err_q <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(split));

endmodule

// File: rtl/ledr_dec.sv
module ledr_dec #(
    parameter int WIDTH      = 8,
    parameter int SKEW_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] val_w,
    input  logic [WIDTH-1:0] phs_w,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_word,
    output logic             skew_err
);
    import ledr_pkg::*;

    logic             exp_q;
    logic [WIDTH-1:0] par;
    logic [WIDTH-1:0] moved;
    par_class_t       cls;
    logic             valid_q;
    logic [WIDTH-1:0] word_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_par
        assign par[i]   = val_w[i] ^ phs_w[i];
        assign moved[i] = par[i] ^ exp_q;
    end

    assign cls       = classify(&moved, ~|moved);
    assign out_valid = valid_q;
    assign out_word  = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q   <= 1'b0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            valid_q <= (cls == PAR_TOKEN);
            if (cls == PAR_TOKEN) begin
                word_q <= val_w;
                exp_q  <= ~exp_q;
            end
        end
    end

    ledr_skew_mon #(.SKEW_LIMIT(SKEW_LIMIT)) u_mon (
        .clk   (clk),
        .rst   (rst),
        .split (cls == PAR_SPLIT),
        .err   (skew_err)
    );

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_no_partial_token_R7: assert property (@(posedge clk) disable iff (rst)
        (cls == PAR_SPLIT) |=> !out_valid);

endmodule

// File: rtl/ledr_link.sv
module ledr_link #(
    parameter int WIDTH      = 8,
    parameter int SKEW_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    input  logic [WIDTH-1:0] tx_word,
    output logic             tx_ready,
    output logic [WIDTH-1:0] tx_val_w,
    output logic [WIDTH-1:0] tx_phs_w,
    input  logic [WIDTH-1:0] rx_val_w,
    input  logic [WIDTH-1:0] rx_phs_w,
    output logic             rx_valid,
    output logic [WIDTH-1:0] rx_word,
    output logic             rx_skew_err
);
    ledr_enc #(.WIDTH(WIDTH)) u_enc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (tx_valid),
        .in_word  (tx_word),
        .in_ready (tx_ready),
        .val_w    (tx_val_w),
        .phs_w    (tx_phs_w)
    );

    ledr_dec #(.WIDTH(WIDTH), .SKEW_LIMIT(SKEW_LIMIT)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .val_w     (rx_val_w),
        .phs_w     (rx_phs_w),
        .out_valid (rx_valid),
        .out_word  (rx_word),
        .skew_err  (rx_skew_err)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (tx_ready && !rx_valid && !rx_skew_err &&
                        tx_val_w == '0 && tx_phs_w == '0));

endmodule

// File: tb/sim_ledr_link.sv
module sim_ledr_link;
    localparam int W   = 8;
    localparam int LIM = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tx_valid = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_ready;
    logic [W-1:0] tx_val_w, tx_phs_w;
    logic [W-1:0] rx_val_w, rx_phs_w;
    logic         rx_valid;
    logic [W-1:0] rx_word;
    logic         rx_skew_err;

    logic         loop_en = 1'b1;
    logic [W-1:0] frc_v = '0;
    logic [W-1:0] frc_p = '0;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] m_val = '0;
    logic [W-1:0] m_phs = '0;

    always #2.5 clk = ~clk;

    assign rx_val_w = loop_en ? tx_val_w : frc_v;
    assign rx_phs_w = loop_en ? tx_phs_w : frc_p;

    ledr_link #(.WIDTH(W), .SKEW_LIMIT(LIM)) u0 (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_word(tx_word),
        .tx_ready(tx_ready), .tx_val_w(tx_val_w), .tx_phs_w(tx_phs_w),
        .rx_val_w(rx_val_w), .rx_phs_w(rx_phs_w), .rx_valid(rx_valid),
        .rx_word(rx_word), .rx_skew_err(rx_skew_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_phase(input logic [W-1:0] v, input logic [W-1:0] p,
                                               input logic [W-1:0] w);
        return p ^ ~(w ^ v);
    endfunction

    task automatic send(input logic [W-1:0] w, input bit hold);
        logic [W-1:0] pv, pp;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_word  = w;
        chk(tx_ready == 1'b1, "R4 ready before send", 32'(tx_ready), 1);
        pv = tx_val_w;
        pp = tx_phs_w;
        @(negedge clk);
        m_phs = exp_phase(m_val, m_phs, w);
        m_val = w;
        chk(tx_val_w == m_val, "R2 value wires", 32'(tx_val_w), 32'(m_val));
        chk(tx_phs_w == m_phs, "R3 phase wires", 32'(tx_phs_w), 32'(m_phs));
        chk(((tx_val_w ^ pv) ^ (tx_phs_w ^ pp)) == '1, "R3 one wire per bit",
            32'((tx_val_w ^ pv) ^ (tx_phs_w ^ pp)), 32'({W{1'b1}}));
        chk(tx_ready == 1'b0, "R4 ready gap", 32'(tx_ready), 0);
        chk(rx_valid == 1'b0, "R6 valid latency", 32'(rx_valid), 0);
        if (hold) tx_word = ~w;
        else tx_valid = 1'b0;
        @(negedge clk);
        chk(rx_valid == 1'b1, "R6 token pulse", 32'(rx_valid), 1);
        chk(rx_word == w, "R6 decoded word", 32'(rx_word), 32'(w));
        chk(tx_ready == 1'b1, "R4 ready back", 32'(tx_ready), 1);
        if (hold) begin
            chk(tx_val_w == m_val && tx_phs_w == m_phs, "R5 held while busy",
                32'({tx_val_w, tx_phs_w}), 32'({m_val, m_phs}));
        end
        tx_valid = 1'b0;
        @(negedge clk);
        chk(rx_valid == 1'b0, "R6 single pulse", 32'(rx_valid), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(tx_val_w == '0 && tx_phs_w == '0, "R1 wires in reset",
            32'({tx_val_w, tx_phs_w}), 0);
        chk(tx_ready && !rx_valid && !rx_skew_err, "R1 flags in reset",
            32'({tx_ready, rx_valid, rx_skew_err}), 32'h4);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_val_w == '0 && tx_phs_w == '0 && tx_ready && !rx_valid && !rx_skew_err,
            "R1 after reset", 32'({tx_val_w, tx_phs_w}), 0);

        send(8'h00, 1'b0);
        send(8'hFF, 1'b0);
        send(8'hFF, 1'b1);
        send(8'h00, 1'b0);
        send(8'hA5, 1'b1);
        send(8'h5A, 1'b0);
        send(8'h5A, 1'b0);

        for (int n = 0; n < 300; n++) begin
            send(W'($urandom), bit'($urandom % 4 == 0));
            repeat ($urandom % 3) @(negedge clk);
        end

        @(negedge clk);
        frc_v = tx_val_w;
        frc_p = tx_phs_w;
        loop_en = 1'b0;
        frc_p = frc_p ^ 8'h0F;
        repeat (LIM) begin
            @(negedge clk);
            chk(rx_valid == 1'b0, "R7 no token on split", 32'(rx_valid), 0);
        end
        chk(rx_skew_err == 1'b0, "R8 split at limit", 32'(rx_skew_err), 0);
        frc_v = frc_v ^ 8'hF0;
        @(negedge clk);
        chk(rx_valid == 1'b1 && rx_word == frc_v, "R6 token after skew",
            32'(rx_word), 32'(frc_v));
        chk(rx_skew_err == 1'b0, "R8 no error after recovery", 32'(rx_skew_err), 0);

        frc_p = frc_p ^ 8'h01;
        repeat (LIM) @(negedge clk);
        chk(rx_skew_err == 1'b0, "R8 before limit exceeded", 32'(rx_skew_err), 0);
        @(negedge clk);
        chk(rx_skew_err == 1'b1, "R9 error raised", 32'(rx_skew_err), 1);
        frc_p = frc_p ^ 8'hFE;
        @(negedge clk);
        chk(rx_valid == 1'b1, "R6 token while error", 32'(rx_valid), 1);
        repeat (3) @(negedge clk);
        chk(rx_skew_err == 1'b1, "R9 error sticky", 32'(rx_skew_err), 1);

        rst = 1'b1;
        loop_en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_skew_err == 1'b0 && tx_ready && tx_val_w == '0 && tx_phs_w == '0,
            "R1 R9 cleared by reset", 32'({rx_skew_err, tx_val_w}), 0);
        m_val = '0;
        m_phs = '0;
        send(8'h3C, 1'b0);

        summary();
    end
endmodule